// File: doc/BRIEF.md
# Disk Position Register with Sector Rollover

This block keeps track of where a disk controller is on the medium. It holds a 9-bit cylinder number, a surface select bit, a disk select bit and a 5-bit sector count. The host writes all four fields at once from a single 16-bit word. The drive logic pulses an end-of-sector line, and the sector count follows it.

Once the sector count reaches its last value, the block advances to the next track. This happens over a short sequence paced by four rotating phase enables. At the first T3, the sector is cleared and a track-advance flag is raised. At the next T4, the cylinder is bumped, but only if the surface bit was already set. At the next T2, the surface bit is flipped. At the following T3, the flag is dropped.

When the move crosses into a new cylinder, a track strobe is held for the whole sequence. A range check flags any cylinder beyond the limit for the unit's density. A 16-bit status word shows either the packed position or an outside current-word address.

Top module: `disk_addr_reg`

## Requirements
- R1: When `ld_stb` is high at a clock edge, the fields take these bits of `ld_word`: cylinder from bits 15..7, surface from bit 6, disk from bit 5, and sector from bits 4..0.
- R2: A falling edge of `sec_inc`, seen as high in one cycle and low in the next, raises the sector count by one (modulo 32). The new value shows in the cycle after the low sample.
- R3: At a T3 phase where the sector count is 29 and no advance is pending, the advance flag sets and the sector count becomes 0 in the next cycle. Any sector increment in that same cycle is dropped.
- R4: While the advance flag is set, a T2 phase inverts the surface bit.
- R5: While the advance flag is set, a T4 phase with the surface bit at 1 adds one to the cylinder, wrapping at 9 bits. If the surface bit is 0, the cylinder does not change.
- R6: `trk_stb` rises with the advance flag when the surface bit is 1 at that T3. Both the flag and `trk_stb` clear at the next T3 phase.
- R7: `addr_err` is high exactly when the cylinder is greater than `LIM_LO` (202) with `hi_dens` at 0, or greater than `LIM_HI` (405) with `hi_dens` at 1.
- R8: With `sel_cwa` at 0, `stat` is {cylinder, surface, disk, sector} in the bit positions of R1. With `sel_cwa` at 1, `stat` equals `cwa`.
- R9: A low `rst_n` clears the cylinder, surface, disk, sector, advance flag and `trk_stb`.
- R10: A load takes priority over every other update in its cycle. It also cancels a pending advance, so `trk_stb` is 0 afterwards and no later phase changes the loaded surface or cylinder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Master clear, active low, asynchronous |
| ld_stb | input | 1 | Load-position strobe |
| ld_word | input | 16 | Packed position word to load |
| sec_inc | input | 1 | End-of-sector level; falling edge advances the sector |
| ph_t2 | input | 1 | Phase T2 one-cycle enable |
| ph_t3 | input | 1 | Phase T3 one-cycle enable |
| ph_t4 | input | 1 | Phase T4 one-cycle enable |
| hi_dens | input | 1 | Selects the high-density cylinder limit |
| sel_cwa | input | 1 | Status source select |
| cwa | input | 16 | External current-word address |
| stat | output | 16 | Status word |
| addr_err | output | 1 | Cylinder above the selected limit |
| trk_stb | output | 1 | Track-address strobe for a cylinder move |

## Verification
A directed run loads sector 28 on surface 1, just past the low-density limit. It steps one sector, then runs two phase rotations. This shows the sector clear, the cylinder bump, the surface flip and the strobe timing as separate events. It also shows the limit switching with density.

A second directed case starts from surface 0. It separates the surface-only advance from the cylinder move. A third loads in the middle of a pending advance, to show that the load cancels it.

Random traffic then mixes loads biased toward sectors 27 to 29, random `sec_inc` toggles, density changes and status selection. The results are compared every cycle against a bench model. This catches errors in priority and in collisions between phases.

// File: rtl/disk_addr_reg.sv
module disk_addr_reg #(
  parameter int CYL_W    = 9,
  parameter int SEC_W    = 5,
  parameter int SEC_LAST = 29,
  parameter int LIM_LO   = 202,
  parameter int LIM_HI   = 405
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld_stb,
  input  logic [CYL_W+SEC_W+1:0]   ld_word,
  input  logic                     sec_inc,
  input  logic                     ph_t2,
  input  logic                     ph_t3,
  input  logic                     ph_t4,
  input  logic                     hi_dens,
  input  logic                     sel_cwa,
  input  logic [CYL_W+SEC_W+1:0]   cwa,
  output logic [CYL_W+SEC_W+1:0]   stat,
  output logic                     addr_err,
  output logic                     trk_stb
);
  localparam int WORD_W = CYL_W + SEC_W + 2;

  logic [CYL_W-1:0] cyl;
  logic [SEC_W-1:0] sec;
  logic             surf, disk, adv, new_cyl, sec_q;

  wire sec_fall = sec_q & ~sec_inc;
  wire roll_go  = ph_t3 & ~adv & (sec == SEC_W'(SEC_LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyl <= '0; sec <= '0; surf <= 1'b0; disk <= 1'b0;
      adv <= 1'b0; new_cyl <= 1'b0; sec_q <= 1'b0;
    end else begin
      sec_q <= sec_inc;
      if (ld_stb) begin
        {cyl, surf, disk, sec} <= ld_word;
        adv     <= 1'b0;
        new_cyl <= 1'b0;
      end else begin
        if (roll_go) begin
          adv     <= 1'b1;
          new_cyl <= surf;
          sec     <= '0;
        end else begin
          if (ph_t3 && adv) begin
            adv     <= 1'b0;
            new_cyl <= 1'b0;
          end
          if (sec_fall) sec <= sec + SEC_W'(1);
        end
        if (adv && ph_t2) surf <= ~surf;
        if (adv && ph_t4 && surf) cyl <= cyl + CYL_W'(1);
      end
    end
  end

  assign addr_err = int'(cyl) > (hi_dens ? LIM_HI : LIM_LO);
  assign stat     = sel_cwa ? cwa : WORD_W'({cyl, surf, disk, sec});
  assign trk_stb  = new_cyl;

  a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stb |=> ({cyl, surf, disk, sec} == $past(ld_word)));
  a_r2_sec_step: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_q && !sec_inc && !ld_stb && !roll_go) |=> (sec == $past(sec) + SEC_W'(1)));
  a_r3_roll_start: assert property (@(posedge clk) disable iff (!rst_n)
    (roll_go && !ld_stb) |=> (adv && sec == '0));
  a_r4_surf_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && ph_t2 && !ld_stb) |=> (surf != $past(surf)));
  a_r5_cyl_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && ph_t4 && surf && !ld_stb) |=> (cyl == $past(cyl) + CYL_W'(1)));
  a_r6_roll_end: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && ph_t3 && !ld_stb) |=> (!adv && !trk_stb));
  a_r10_ld_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stb |=> !trk_stb);
endmodule

// File: tb/sim_disk_addr_reg.sv
`timescale 1ns/1ps
module sim_disk_addr_reg;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ld_stb = 0, sec_inc = 0, ph_t2 = 0, ph_t3 = 0, ph_t4 = 0, hi_dens = 0, sel_cwa = 0;
  logic [15:0] ld_word = '0, cwa = '0;
  logic [15:0] stat;
  logic addr_err, trk_stb;
  int n_run = 0, n_fail = 0, ph = 0;

  logic [8:0] m_cyl; logic [4:0] m_sec; logic m_surf, m_disk, m_adv, m_nc, m_secq;

  always #2.5 clk = ~clk;

  disk_addr_reg u0 (.clk, .rst_n, .ld_stb, .ld_word, .sec_inc, .ph_t2, .ph_t3, .ph_t4,
                    .hi_dens, .sel_cwa, .cwa, .stat, .addr_err, .trk_stb);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic m_reset();
    m_cyl = 0; m_sec = 0; m_surf = 0; m_disk = 0; m_adv = 0; m_nc = 0; m_secq = 0;
  endtask

  task automatic m_step();
    logic fall, go, os;
    fall = m_secq & ~sec_inc;
    go = ph_t3 & ~m_adv & (m_sec == 5'd29);
    os = m_surf;
    m_secq = sec_inc;
    if (ld_stb) begin
      {m_cyl, m_surf, m_disk, m_sec} = ld_word; m_adv = 0; m_nc = 0;
    end else begin
      logic a0; a0 = m_adv;
      if (go) begin m_adv = 1; m_nc = os; m_sec = 0; end
      else begin
        if (ph_t3 && a0) begin m_adv = 0; m_nc = 0; end
        if (fall) m_sec = m_sec + 5'd1;
      end
      if (a0 && ph_t2) m_surf = ~os;
      if (a0 && ph_t4 && os) m_cyl = m_cyl + 9'd1;
    end
  endtask

  function automatic bit m_err();
    return int'(m_cyl) > (hi_dens ? 405 : 202);
  endfunction

  task automatic check_all();
    if (sel_cwa) chk(stat == cwa, "R8 cwa", stat, cwa);
    else begin
      chk(stat[15:7] == m_cyl, "R5 cylinder", stat[15:7], m_cyl);
      chk(stat[6] == m_surf, "R4 surface", stat[6], m_surf);
      chk(stat[5] == m_disk, "R1 disk", stat[5], m_disk);
      chk(stat[4:0] == m_sec, "R2 sector", stat[4:0], m_sec);
    end
    chk(addr_err == m_err(), "R7 addr_err", addr_err, m_err());
    chk(trk_stb == m_nc, "R6 trk_stb", trk_stb, m_nc);
  endtask

  task automatic cyc();
    @(posedge clk); #1 m_step();
    @(negedge clk); check_all();
    ph = (ph + 1) % 4;
    ph_t2 = (ph == 1); ph_t3 = (ph == 2); ph_t4 = (ph == 3);
  endtask

  initial begin
    #(200000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    m_reset();
    repeat (3) @(negedge clk);
    chk(stat == 16'h0 && !trk_stb, "R9 reset", stat, 0);
    rst_n = 1;
    // R1/R7: load cyl 203, surf 1, disk 0, sector 28
    ld_word = {9'd203, 1'b1, 1'b0, 5'd28}; ld_stb = 1; cyc(); ld_stb = 0;
    chk(stat == {9'd203, 1'b1, 1'b0, 5'd28}, "R1 load", stat, {9'd203, 1'b1, 1'b0, 5'd28});
    chk(addr_err == 1'b1, "R7 low density limit", addr_err, 1);
    hi_dens = 1; #0.1;
    chk(addr_err == 1'b0, "R7 high density limit", addr_err, 0);
    hi_dens = 0;
    sec_inc = 1; cyc(); sec_inc = 0; cyc();
    chk(stat[4:0] == 5'd29, "R2 sector step", stat[4:0], 29);
    repeat (8) cyc();
    chk(stat == {9'd204, 1'b0, 1'b0, 5'd0}, "R3 R5 rollover result", stat, {9'd204, 1'b0, 1'b0, 5'd0});
    chk(trk_stb == 1'b0, "R6 strobe cleared", trk_stb, 0);
    // surface 0 -> no cylinder step
    ld_word = {9'd10, 1'b0, 1'b1, 5'd29}; ld_stb = 1; cyc(); ld_stb = 0;
    repeat (8) cyc();
    chk(stat == {9'd10, 1'b1, 1'b1, 5'd0}, "R4 surface-only advance", stat, {9'd10, 1'b1, 1'b1, 5'd0});
    // R10: load cancels pending advance
    ld_word = {9'd50, 1'b1, 1'b0, 5'd29}; ld_stb = 1; cyc(); ld_stb = 0;
    while (!ph_t3) cyc();
    cyc();
    ld_word = {9'd77, 1'b1, 1'b1, 5'd3}; ld_stb = 1; cyc(); ld_stb = 0;
    repeat (8) cyc();
    chk(stat == {9'd77, 1'b1, 1'b1, 5'd3} && !trk_stb, "R10 load cancels", stat, {9'd77, 1'b1, 1'b1, 5'd3});
    for (int i = 0; i < 4000; i++) begin
      ld_stb = ($urandom % 24) == 0;
      ld_word = $urandom;
      if ($urandom % 2) ld_word[4:0] = 5'd27 + 5'($urandom % 3);
      if ($urandom % 3 == 0) sec_inc = ~sec_inc;
      if ($urandom % 50 == 0) hi_dens = ~hi_dens;
      sel_cwa = ($urandom % 5) == 0;
      cwa = $urandom;
      cyc();
    end
    rst_n = 0; m_reset(); #1;
    chk(stat == 16'h0 && !trk_stb, "R9 reset after traffic", stat, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule